// File: doc/BRIEF.md
# Rotating Pattern Memory Initializer

This block fills a memory of 64-bit words with a fixed, repeatable pattern after a start request. The pattern comes from two 64-bit state words that take turns updating each other. The word being updated becomes the other word, rotated right by its own old value, plus a step constant. Each update produces one pair of adjacent entries. The block drives a write port with an entry address, a 128-bit data word that covers the two entries, and a write enable.

The fill runs one update per clock. With the default parameters that is 1024 updates, which cover 2048 entries. A single-cycle done pulse follows the last write. A start request made while a fill is running is ignored. Every accepted start reloads the two seed values, so each fill writes the same contents.

Top module: `rotfill_top`

## Requirements
- R1: After reset, and for as long as no start has been accepted, `wr_en_o` and `done_o` are 0.
- R2: A start seen while idle is accepted. The first write occurs in the next cycle at entry address 0.
- R3: A fill makes exactly DEPTH/2 writes, one per cycle with no gap. The entry address rises by 2 on each write, from 0 to DEPTH-2.
- R4: Every accepted start loads state word A with 0x0123456789ABCDEF and state word B with 0xFEDCBA9876543210, so repeated fills write identical contents.
- R5: Within each group of 16 entries, steps are numbered 1 to 8. Step s writes entries 2(s-1) and 2(s-1)+1 of the group. On odd steps, A takes the value of B rotated right by the old A, plus the step constant. `wr_data_o[63:0]` (the lower entry) carries the new A and `wr_data_o[127:64]` (the upper entry) carries the old A.
- R6: On even steps, B takes the value of the current A rotated right by the old B, plus the step constant. The lower entry carries the new B and the upper entry carries the old B.
- R7: The step constant of step s is s × 0x111 (0x111 up to 0x888), and the sequence restarts in every group.
- R8: The rotate amount is the low 6 bits of the old value of the word being replaced, so it is taken mod 64.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last write, and no write occurs in that cycle.
- R10: Start requests made during a fill change neither the address sequence nor the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Fill request, acted on only when idle |
| wr_en_o | output | 1 | Write enable for the entry pair |
| wr_addr_o | output | 11 | Entry address of the lower entry (always even) |
| wr_data_o | output | 128 | [63:0] lower entry, [127:64] upper entry |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The fill is run three times, each time after a random idle gap. In the first run, random start pulses arrive during the fill. Those runs show that mid-fill starts are ignored (R10) and that each new start reloads the seeds rather than continuing from the previous state. The second run starts from a cleared memory and the third from a poisoned one, so any entry the block fails to write shows up as a mismatch. Every entry is compared with a reference fill computed in the bench. That comparison separates the odd-step and even-step update rules, catches a wrong or non-repeating step constant, and catches a rotate amount that is not reduced mod 64. Checks on the address sequence and on the exact cycle of the done pulse catch skipped or extra writes and a late or stretched completion.

// File: rtl/rotfill_pkg.sv
// Shared types and default constants for the rotating pattern initializer.
// Assumes the defaults are used with a 64-bit word width.
package rotfill_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;

    localparam logic [63:0] DEF_SEED_A   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] DEF_SEED_B   = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] DEF_STEP_INC = 64'h0000_0000_0000_0111;

endpackage

// File: rtl/rotfill_seq.sv
// Sequencer: accepts a start while idle, counts entry pairs once per cycle,
// and pulses done after the last pair. Assumes PAIRS is a power of two.
module rotfill_seq #(
    parameter int PAIRS  = 1024,
    localparam int PAIR_W = $clog2(PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              run_o,
    output logic              load_o,
    output logic [PAIR_W-1:0] pair_o,
    output logic              done_o
);
    import rotfill_pkg::*;

    localparam logic [PAIR_W-1:0] PAIR_ONE  = PAIR_W'(1);
    localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(PAIRS - 1);

    fill_state_e       state_q;
    logic [PAIR_W-1:0] pair_q;
    logic              done_q;

    // Seed load request: only a start seen while idle counts.
    always_comb begin
        load_o = start_i && (state_q == FILL_IDLE);
    end

    // State, pair counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            pair_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                FILL_IDLE: begin
                    if (start_i) begin
                        state_q <= FILL_RUN;
                        pair_q  <= '0;
                    end
                end
                FILL_RUN: begin
                    if (pair_q == PAIR_LAST) begin
                        state_q <= FILL_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        pair_q <= pair_q + PAIR_ONE;
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    // Outputs come straight from registers.
    always_comb begin
        run_o  = (state_q == FILL_RUN);
        pair_o = pair_q;
        done_o = done_q;
    end

endmodule

// File: rtl/rotfill_dp.sv
// Pattern datapath: two state words that update each other in turn. Odd
// steps (step index bit 0 clear) replace A, even steps replace B. One shared
// rotator and one adder produce the fresh word. Assumes W is a power of two.
module rotfill_dp #(
    parameter int              W        = 64,
    parameter int              STEPS    = 8,
    parameter logic [W-1:0]    SEED_A   = rotfill_pkg::DEF_SEED_A,
    parameter logic [W-1:0]    SEED_B   = rotfill_pkg::DEF_SEED_B,
    parameter logic [W-1:0]    STEP_INC = rotfill_pkg::DEF_STEP_INC,
    localparam int             STEP_W   = $clog2(STEPS),
    localparam int             SH_W     = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [W-1:0]      lo_o,
    output logic [W-1:0]      hi_o
);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    logic [W-1:0]    reg_a_q;
    logic [W-1:0]    reg_b_q;
    logic [W-1:0]    k_q;
    logic            odd_step;
    logic [W-1:0]    rot_src;
    logic [SH_W-1:0] rot_amt;
    logic [W-1:0]    rot_res;
    logic [W-1:0]    fresh;

    // Rotate right by n, with n already reduced to SH_W bits.
    function automatic logic [W-1:0] rotr(input logic [W-1:0] v,
                                          input logic [SH_W-1:0] n);
        logic [2*W-1:0] dbl;
        dbl = {v, v} >> n;
        return dbl[W-1:0];
    endfunction

    // Select the rotator operands by step parity and form the fresh word.
    always_comb begin
        odd_step = ~step_i[0];
        rot_src  = odd_step ? reg_b_q : reg_a_q;
        rot_amt  = odd_step ? reg_a_q[SH_W-1:0] : reg_b_q[SH_W-1:0];
        rot_res  = rotr(rot_src, rot_amt);
        fresh    = rot_res + k_q;
        lo_o     = fresh;
        hi_o     = odd_step ? reg_a_q : reg_b_q;
    end

    // State words: seeds on reset or load, one replaced per step.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            reg_a_q <= SEED_A;
            reg_b_q <= SEED_B;
        end else if (adv_i) begin
            if (odd_step) begin
                reg_a_q <= fresh;
            end else begin
                reg_b_q <= fresh;
            end
        end
    end

    // Step constant accumulator: restarts at the first step of every group.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            k_q <= STEP_INC;
        end else if (adv_i) begin
            k_q <= (step_i == STEP_LAST) ? STEP_INC : (k_q + STEP_INC);
        end
    end

endmodule

// File: rtl/rotfill_top.sv
// Rotating pattern memory initializer top: sequencer plus pattern datapath
// driving a two-entry write port. Assumes DEPTH and GROUP are powers of two,
// with GROUP dividing DEPTH.
module rotfill_top #(
    parameter int                 DEPTH    = 2048,
    parameter int                 WORD_W   = 64,
    parameter int                 GROUP    = 16,
    parameter logic [WORD_W-1:0]  SEED_A   = rotfill_pkg::DEF_SEED_A,
    parameter logic [WORD_W-1:0]  SEED_B   = rotfill_pkg::DEF_SEED_B,
    parameter logic [WORD_W-1:0]  STEP_INC = rotfill_pkg::DEF_STEP_INC,
    localparam int                ADDR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [2*WORD_W-1:0] wr_data_o,
    output logic                done_o
);
    localparam int PAIRS  = DEPTH / 2;
    localparam int STEPS  = GROUP / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int STEP_W = $clog2(STEPS);

    logic              run;
    logic              load;
    logic [PAIR_W-1:0] pair;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;

    rotfill_seq #(
        .PAIRS (PAIRS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .run_o   (run),
        .load_o  (load),
        .pair_o  (pair),
        .done_o  (done_o)
    );

    rotfill_dp #(
        .W        (WORD_W),
        .STEPS    (STEPS),
        .SEED_A   (SEED_A),
        .SEED_B   (SEED_B),
        .STEP_INC (STEP_INC)
    ) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (run),
        .step_i (pair[STEP_W-1:0]),
        .lo_o   (lo_word),
        .hi_o   (hi_word)
    );

    // Write port: pair index scaled to an entry address, lower entry in low half.
    always_comb begin
        wr_en_o   = run;
        wr_addr_o = {pair, 1'b0};
        wr_data_o = {hi_word, lo_word};
    end

endmodule

// File: rtl/rotfill_chk.sv
// Protocol checker for rotfill_top, attached by bind. Checks ordering,
// completion timing and the chaining between successive writes.
module rotfill_chk #(
    parameter int  DEPTH  = 2048,
    parameter int  WORD_W = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                wr_en_o,
    input logic [ADDR_W-1:0]   wr_addr_o,
    input logic [2*WORD_W-1:0] wr_data_o,
    input logic                done_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] ADDR_TWO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_FOUR = ADDR_W'(4);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !start_i) |=> !wr_en_o);

    a_r2_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wr_en_o) |=> (wr_en_o && wr_addr_o == '0));

    // R3 and R10: contiguous addresses whatever start does
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o != LAST_ADDR) |=>
            (wr_en_o && wr_addr_o == $past(wr_addr_o) + ADDR_TWO));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == LAST_ADDR) |=> (done_o && !wr_en_o));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o));

    // R5 and R6: the old word of a step is the fresh word written two steps earlier
    a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o >= ADDR_FOUR) |->
            (wr_data_o[2*WORD_W-1:WORD_W] == $past(wr_data_o[WORD_W-1:0], 2)));

endmodule

bind rotfill_top rotfill_chk #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o)
);

// File: tb/sim_rotfill_top.sv
// Bench for rotfill_top: behavioural RAM, reference fill, random start noise.
module sim_rotfill_top;

    localparam int DEPTH = 2048;
    localparam int AW    = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           wr_en_o;
    logic [AW-1:0]  wr_addr_o;
    logic [127:0]   wr_data_o;
    logic           done_o;

    logic [63:0] mem     [DEPTH];
    logic [63:0] ref_mem [DEPTH];

    int n_checks = 0;
    int n_fails  = 0;
    int n_writes = 0;
    int last_wr  = -1;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rotfill_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .done_o    (done_o)
    );

    function automatic void chk(input bit ok, input string tag,
                                input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic logic [63:0] rot_right(input logic [63:0] v, input logic [63:0] n);
        int s = int'(n % 64);
        if (s == 0) return v;
        return (v >> s) | (v << (64 - s));
    endfunction

    // Reference fill computed directly from the requirements.
    task automatic build_ref();
        logic [63:0] a = 64'h0123456789ABCDEF;
        logic [63:0] b = 64'hFEDCBA9876543210;
        for (int g = 0; g < DEPTH; g += 16) begin
            for (int s = 1; s <= 8; s++) begin
                logic [63:0] k = 64'(s) * 64'h111;
                int base = g + 2 * (s - 1);
                if (s % 2 == 1) begin
                    logic [63:0] old = a;
                    a = rot_right(b, old) + k;
                    ref_mem[base] = a;
                    ref_mem[base + 1] = old;
                end else begin
                    logic [63:0] old = b;
                    b = rot_right(a, old) + k;
                    ref_mem[base] = b;
                    ref_mem[base + 1] = old;
                end
            end
        end
    endtask

    // Behavioural RAM and address-sequence monitor (R3 and R10).
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            chk(int'(wr_addr_o) == 2 * n_writes, "R3 R10 address order",
                64'(wr_addr_o), 64'(2 * n_writes));
            mem[wr_addr_o]        = wr_data_o[63:0];
            mem[wr_addr_o + 11'd1] = wr_data_o[127:64];
            last_wr = int'(wr_addr_o);
            n_writes++;
        end
    end

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(wr_en_o == 1'b0 && done_o == 1'b0, "R1 idle outputs",
                64'({wr_en_o, done_o}), 64'd0);
        end
    endtask

    // One fill; noisy=1 throws random start pulses at the block while it runs.
    task automatic run_fill(input bit noisy);
        int guard = 0;
        n_writes = 0;
        last_wr  = -1;
        start_i  = 1'b1;
        @(negedge clk);
        chk(wr_en_o == 1'b1 && wr_addr_o == '0, "R2 first write",
            64'({wr_en_o, wr_addr_o}), 64'({1'b1, 11'd0}));
        start_i = noisy ? ($urandom % 8 == 0) : 1'b0;
        while (!done_o && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (done_o) start_i = 1'b0;
            else        start_i = noisy ? ($urandom % 8 == 0) : 1'b0;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R9 done seen", 64'(done_o), 64'd1);
        chk(wr_en_o == 1'b0, "R9 no write with done", 64'(wr_en_o), 64'd0);
        chk(last_wr == DEPTH - 2, "R9 done follows last write", 64'(last_wr), 64'(DEPTH - 2));
        chk(n_writes == DEPTH / 2, "R3 write count", 64'(n_writes), 64'(DEPTH / 2));
        @(negedge clk);
        chk(done_o == 1'b0 && wr_en_o == 1'b0, "R9 done is one cycle",
            64'({done_o, wr_en_o}), 64'd0);
    endtask

    task automatic compare_mem(input string run_tag);
        for (int i = 0; i < DEPTH; i++) begin
            // entries 0,1 of every 4 belong to odd steps
            if (i % 4 < 2)
                chk(mem[i] === ref_mem[i], {run_tag, " R5 R7 R8 odd-step entry"}, mem[i], ref_mem[i]);
            else
                chk(mem[i] === ref_mem[i], {run_tag, " R6 R7 R8 even-step entry"}, mem[i], ref_mem[i]);
        end
        chk(mem[1] === 64'h0123456789ABCDEF, {run_tag, " R4 seed A"}, mem[1], 64'h0123456789ABCDEF);
        chk(mem[3] === 64'hFEDCBA9876543210, {run_tag, " R4 seed B"}, mem[3], 64'hFEDCBA9876543210);
    endtask

    initial begin
        void'($urandom(32'd20180213));
        build_ref();
        for (int i = 0; i < DEPTH; i++) mem[i] = 64'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en_o == 1'b0 && done_o == 1'b0, "R1 reset state",
            64'({wr_en_o, done_o}), 64'd0);
        idle_gap(3 + int'($urandom % 20));

        // Fill 1: random starts during the run must be ignored (R10)
        run_fill(1'b1);
        compare_mem("fill1");

        // Fill 2: memory cleared, seeds must reload (R4)
        for (int i = 0; i < DEPTH; i++) mem[i] = 64'h0;
        idle_gap(1 + int'($urandom % 10));
        run_fill(1'b0);
        compare_mem("fill2");

        // Fill 3: memory poisoned, directed start straight after idle
        for (int i = 0; i < DEPTH; i++) mem[i] = {$urandom, $urandom};
        idle_gap(1);
        run_fill(1'b1);
        compare_mem("fill3");
        idle_gap(5);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule